// File: doc/BRIEF.md
# Clock Generator Controller with Aligned Post-Dividers

This block controls a clock generator through a small register interface and stands in for the analog loop with a behavioural model. Software moves the generator through a fixed sequence of steps. It selects bypass, holds the loop in reset, powers it up and enables it, and loads a multiplier and the post-divider ratios. It then issues an alignment command and waits until the command is no longer busy. After that it releases the reset, waits for lock, and only then selects locked operation. The reference source selection and one companion bypass bit are kept as register state only.

The lock model is a counter in the reference domain. It reports lock a fixed number of reference cycles after the loop leaves reset while powered. A request for locked operation made before lock leaves the output in bypass. Each post-divider produces a one-cycle enable pulse at the divided rate, counted in reference cycles. A new divider ratio written by software is only held in a staging register. It becomes active at the end of an alignment command, and both dividers restart together at that point so their phases line up.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x100) reads 0x012: bypass, powered down (bit 1), loop reset asserted (bit 3 = 0), disabled (bit 4). Divider words and status read 0; `locked` and `pll_mode` are 0, `clk_ratio` is 1 and no divider pulses occur.
- R2: A read returns data one cycle after `rd_en`. Only control bits 0, 1, 3, 4, 5 and 8 are stored (a write of all ones reads back 0x13B). The multiplier (0x110) keeps MULT_W bits. Divider words (0x118, 0x11C) keep the ratio in the low DIV_W bits and the enable in bit 15. Unmapped offsets read 0.
- R3: A control write with bit 0 (locked operation) equal to 0 also clears bit 5, whatever value is written to bit 5. Bit 8 is kept.
- R4: `locked` rises exactly LOCK_CYC cycles after the write that leaves bit 3 = 1 with bit 1 = 0. It falls one cycle after a write that powers down the loop or asserts its reset.
- R5: `pll_mode` is 1 only when control bit 0 is 1, bit 4 is 0 and lock was present in the previous cycle. It follows a qualifying change after one cycle, and a request made before lock keeps the output in bypass.
- R6: `clk_ratio` equals multiplier + 1 while `pll_mode` is 1, and 1 otherwise.
- R7: Writing 1 to bit 0 of the command word (0x138) sets status bit 0 (0x13C) for exactly ALIGN_CYC cycles. A command issued while busy has no effect.
- R8: Divider ratio writes read back at once but leave the active division unchanged until the busy status clears. At that point the staged ratios become active.
- R9: Divider k pulses `div_tick[k]` once every ratio+1 cycles while its enable bit 15 is 1, and never while that bit is 0.
- R10: While alignment is busy, both dividers are silent. When busy clears, both restart from zero, so each first pulse comes ratio+1 cycles later and the slower divider's pulses coincide with the faster one's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| pll_mode | output | 1 | 1 = locked operation, 0 = bypass |
| clk_ratio | output | MULT_W+1 | Effective output rate in units of the reference rate |
| locked | output | 1 | Lock indication from the lock-wait counter |
| div_tick | output | NUM_DIV | Divided-clock enable pulses |

## Verification
The bench targets the exact lock edge. A counter off by one would raise `locked` a cycle early or late, and a mode stage that ignored lock would leave bypass while the counter was still running. Divider staging is observed through the pulse period before and after an alignment command. A design that applied ratios on write would change the period before busy clears, and one that did not restart the counters together would misalign the two pulse trains. The bench also re-issues the command while busy, which exposes a sequencer that restarts its count. It writes the companion bypass bit to catch a control register that keeps it while bit 0 is cleared.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  // Register byte offsets
  localparam int CTRL_OFF = 'h100;
  localparam int MULT_OFF = 'h110;
  localparam int DIV_BASE = 'h118;
  localparam int CMD_OFF  = 'h138;
  localparam int STAT_OFF = 'h13C;

  // Control word layout
  localparam int CTRL_W    = 9;
  localparam int B_PLLSEL  = 0;
  localparam int B_PWRDN   = 1;
  localparam int B_RELEASE = 3;
  localparam int B_DISABLE = 4;
  localparam int B_AUX     = 5;
  localparam int B_SRC     = 8;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 9'h13B;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 9'h012;

  // Divider word layout
  localparam int DIV_ON_BIT = 15;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int MULT_W  = 5,
  parameter int DIV_W   = 5,
  parameter int NUM_DIV = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  input  logic                           busy,
  output logic                           go,
  output logic [CTRL_W-1:0]              ctrl,
  output logic [MULT_W-1:0]              mult,
  output logic [NUM_DIV-1:0][DIV_W-1:0]  div_stage,
  output logic [NUM_DIV-1:0]             div_on
);
  logic [CTRL_W-1:0] ctrl_wr;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  // Control write value: clearing locked operation drops the companion bit
  always_comb begin
    ctrl_wr = wdata[CTRL_W-1:0] & CTRL_MASK;
    if (!ctrl_wr[B_PLLSEL]) ctrl_wr[B_AUX] = 1'b0;
  end

  assign go = wr_en && (addr == ADDR_W'(CMD_OFF)) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= CTRL_RST;
      mult      <= '0;
      div_stage <= '0;
      div_on    <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(CTRL_OFF)) ctrl <= ctrl_wr;
      if (addr == ADDR_W'(MULT_OFF)) mult <= wdata[MULT_W-1:0];
      for (int i = 0; i < NUM_DIV; i++) begin
        if (addr == ADDR_W'(DIV_BASE + 4*i)) begin
          div_stage[i] <= wdata[DIV_W-1:0];
          div_on[i]    <= wdata[DIV_ON_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (addr == ADDR_W'(CTRL_OFF)) rd_nxt[CTRL_W-1:0] = ctrl;
    if (addr == ADDR_W'(MULT_OFF)) rd_nxt[MULT_W-1:0] = mult;
    if (addr == ADDR_W'(STAT_OFF)) rd_nxt[0] = busy;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (addr == ADDR_W'(DIV_BASE + 4*i)) begin
        rd_nxt[DIV_W-1:0]   = div_stage[i];
        rd_nxt[DIV_ON_BIT]  = div_on[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/clkgen_align.sv
module clkgen_align #(
  parameter int ALIGN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (ALIGN_CYC > 1) ? $clog2(ALIGN_CYC) : 1;
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(ALIGN_CYC - 1);
    end
  end
endmodule

// File: rtl/clkgen_lock.sv
module clkgen_lock #(
  parameter int LOCK_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic released,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !released) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(LOCK_CYC - 1)) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  input  logic             hold,
  input  logic             load,
  input  logic [DIV_W-1:0] stage,
  output logic [DIV_W-1:0] active,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       active <= '0;
    else if (load) active <= stage;
  end

  always_ff @(posedge clk) begin
    if (rst || !on || hold) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == active) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MULT_W    = 5,
  parameter int DIV_W     = 5,
  parameter int NUM_DIV   = 2,
  parameter int LOCK_CYC  = 64,
  parameter int ALIGN_CYC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               pll_mode,
  output logic [MULT_W:0]    clk_ratio,
  output logic               locked,
  output logic [NUM_DIV-1:0] div_tick
);
  logic [CTRL_W-1:0]             ctrl;
  logic [MULT_W-1:0]             mult;
  logic [NUM_DIV-1:0][DIV_W-1:0] div_stage;
  logic [NUM_DIV-1:0][DIV_W-1:0] div_active;
  logic [NUM_DIV-1:0]            div_on;
  logic                          go;
  logic                          busy;
  logic                          align_done;
  logic                          released;
  logic                          mode_nxt;
  logic                          unused_ctrl;

  assign unused_ctrl = ctrl[B_SRC] ^ ctrl[B_AUX] ^ ctrl[2] ^ ctrl[6] ^ ctrl[7];

  clkgen_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MULT_W(MULT_W),
    .DIV_W(DIV_W), .NUM_DIV(NUM_DIV)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .go(go), .ctrl(ctrl),
    .mult(mult), .div_stage(div_stage), .div_on(div_on)
  );

  clkgen_align #(.ALIGN_CYC(ALIGN_CYC)) u_align (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .done(align_done)
  );

  assign released = ctrl[B_RELEASE] && !ctrl[B_PWRDN];

  clkgen_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .released(released), .locked(locked)
  );

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    clkgen_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .on(div_on[k]), .hold(busy), .load(align_done),
      .stage(div_stage[k]), .active(div_active[k]), .tick(div_tick[k])
    );
  end

  assign mode_nxt = ctrl[B_PLLSEL] && !ctrl[B_DISABLE] && locked && released;

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_mode  <= 1'b0;
      clk_ratio <= (MULT_W+1)'(1);
    end else begin
      pll_mode  <= mode_nxt;
      clk_ratio <= mode_nxt ? ((MULT_W+1)'(mult) + 1'b1) : (MULT_W+1)'(1);
    end
  end
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
  parameter int MULT_W  = 5,
  parameter int DIV_W   = 5,
  parameter int NUM_DIV = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           pll_mode,
  input logic [MULT_W:0]                clk_ratio,
  input logic                           locked,
  input logic                           busy,
  input logic                           go,
  input logic [NUM_DIV-1:0]             div_on,
  input logic [NUM_DIV-1:0]             div_tick,
  input logic [NUM_DIV-1:0][DIV_W-1:0]  div_stage,
  input logic [NUM_DIV-1:0][DIV_W-1:0]  div_active
);
  p_mode_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
    pll_mode |-> $past(locked));

  p_bypass_ratio_r6: assert property (@(posedge clk) disable iff (rst)
    !pll_mode |-> (clk_ratio == (MULT_W+1)'(1)));

  p_busy_from_go_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));

  p_load_on_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (div_active == $past(div_stage)));

  p_active_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(div_active));

  p_tick_gated_r9: assert property (@(posedge clk) disable iff (rst)
    div_tick[0] |-> $past(div_on[0]));

  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (div_tick == '0));
endmodule

bind clkgen_ctrl clkgen_chk #(.MULT_W(MULT_W), .DIV_W(DIV_W), .NUM_DIV(NUM_DIV)) u_chk (
  .clk(clk), .rst(rst), .pll_mode(pll_mode), .clk_ratio(clk_ratio),
  .locked(locked), .busy(busy), .go(go), .div_on(div_on),
  .div_tick(div_tick), .div_stage(div_stage), .div_active(div_active)
);

// File: tb/sim_clkgen_ctrl.sv
`timescale 1ns/1ps
module sim_clkgen_ctrl;
  localparam int ADDR_W = 12, DATA_W = 32, MULT_W = 5, DIV_W = 5, NUM_DIV = 2;
  localparam int LOCK_CYC = 64, ALIGN_CYC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic pll_mode, locked;
  logic [MULT_W:0] clk_ratio;
  logic [NUM_DIV-1:0] div_tick;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkgen_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MULT_W(MULT_W), .DIV_W(DIV_W),
    .NUM_DIV(NUM_DIV), .LOCK_CYC(LOCK_CYC), .ALIGN_CYC(ALIGN_CYC)
  ) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pll_mode(pll_mode), .clk_ratio(clk_ratio),
    .locked(locked), .div_tick(div_tick)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, output int e);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    e = cyc;
  endtask

  task automatic rd_at(input int t, input int a, output logic [31:0] d);
    wait_cyc(t - 1);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_at(cyc + 1, a, d);
  endtask

  task automatic period(input int k, output int p);
    int guard;
    guard = 0;
    while (!div_tick[k] && guard < 100) begin @(negedge clk); guard++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!div_tick[k] && p < 100);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 locked", 32'(locked), 0);
    chk("R1 pll_mode", 32'(pll_mode), 0);
    chk("R1 clk_ratio", 32'(clk_ratio), 1);
    chk("R1 div_tick", 32'(div_tick), 0);
    rd('h100, d); chk("R1 ctrl", d, 32'h012);
    rd('h118, d); chk("R1 div0", d, 0);
    rd('h13C, d); chk("R1 status", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d; int e;
    wr('h100, 32'hFFFF_FFFF, e); rd('h100, d); chk("R2 ctrl mask", d, 32'h13B);
    wr('h110, 32'hFFFF_FFFF, e); rd('h110, d); chk("R2 mult mask", d, 32'h1F);
    wr('h11C, 32'hFFFF_7FE3, e); rd('h11C, d); chk("R2 div1 mask", d, 32'h03);
    rd('h104, d); chk("R2 unmapped", d, 0);
    wr('h100, 32'h21, e); rd('h100, d); chk("R3 aux kept with bit0", d, 32'h21);
    wr('h100, 32'h120, e); rd('h100, d); chk("R3 aux cleared by bypass", d, 32'h100);
    wr('h11C, 0, e);
    wr('h100, 32'h012, e);
  endtask

  task automatic t_lock_mode;
    int e;
    wr('h110, 16, e);
    wr('h100, 32'h19, e);
    wait_cyc(e + LOCK_CYC - 1); chk("R4 not yet locked", 32'(locked), 0);
    wait_cyc(e + LOCK_CYC);     chk("R4 locked on time", 32'(locked), 1);
    wait_cyc(e + LOCK_CYC + 2); chk("R5 disabled stays bypass", 32'(pll_mode), 0);
    wr('h100, 32'h09, e);
    chk("R5 one cycle latency", 32'(pll_mode), 0);
    wait_cyc(e + 1);
    chk("R5 locked operation", 32'(pll_mode), 1);
    chk("R6 ratio mult+1", 32'(clk_ratio), 17);
    wr('h100, 32'h00, e);
    wait_cyc(e + 2);
    chk("R4 reset drops lock", 32'(locked), 0);
    chk("R6 bypass ratio", 32'(clk_ratio), 1);
    wr('h100, 32'h09, e);
    wait_cyc(e + 10);           chk("R5 early request bypass", 32'(pll_mode), 0);
    wait_cyc(e + LOCK_CYC);     chk("R5 bypass at lock edge", 32'(pll_mode), 0);
    wait_cyc(e + LOCK_CYC + 1); chk("R5 mode after lock", 32'(pll_mode), 1);
    wr('h100, 32'h0B, e);
    wait_cyc(e + 1);
    chk("R4 powerdown drops lock", 32'(locked), 0);
    chk("R5 powerdown bypass", 32'(pll_mode), 0);
    chk("R6 powerdown ratio", 32'(clk_ratio), 1);
  endtask

  task automatic t_divider;
    logic [31:0] d; int e, g, p;
    wr('h118, 32'h8001, e);
    wr('h11C, 32'h8003, e);
    rd('h118, d); chk("R8 staged readback", d, 32'h8001);
    period(0, p); chk("R8 old ratio still active", 32'(p), 1);
    wait_cyc(cyc + 1);
    wr('h138, 1, g);
    rd_at(g + 1, 'h13C, d); chk("R7 busy set", d, 1);
    wait_cyc(g + 4); chk("R10 quiet while busy", 32'(div_tick), 0);
    rd_at(g + ALIGN_CYC, 'h13C, d); chk("R7 busy last cycle", d, 1);
    rd_at(g + ALIGN_CYC + 1, 'h13C, d); chk("R7 busy cleared", d, 0);
    chk("R10 no pulse right after load", 32'(div_tick), 0);
    wait_cyc(g + ALIGN_CYC + 2); chk("R10 first pulses", 32'(div_tick), 1);
    wait_cyc(g + ALIGN_CYC + 3); chk("R10 gap", 32'(div_tick), 0);
    wait_cyc(g + ALIGN_CYC + 4); chk("R10 aligned pulses", 32'(div_tick), 3);
    period(1, p); chk("R9 div1 period", 32'(p), 4);
    wr('h118, 32'h8002, e);
    period(0, p); chk("R8 period before go", 32'(p), 2);
    wr('h138, 1, g);
    wait_cyc(g + 2);
    wr('h138, 1, e);
    rd_at(g + ALIGN_CYC + 1, 'h13C, d); chk("R7 retrigger ignored", d, 0);
    period(0, p); chk("R9 div0 new period", 32'(p), 3);
    wr('h11C, 32'h0003, e);
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (div_tick[1]) seen++;
      end
      chk("R9 disabled divider silent", 32'(seen), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_lock_mode();
    t_divider();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule